// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block holds the interrupt control and status word of a seven-channel DMA engine and drives the single interrupt request line that the engine presents to the system interrupt controller. Each channel signals the end of its transfer with a one-cycle completion strobe. The block sets that channel's flag only if the channel's enable is set. After any flag-setting event it works out the master flag from a force bit, a master enable and the channel flags. When the master condition holds, it sends a one-clock interrupt pulse.

One channel is the delayed channel, which is channel 6 by default. It does not complete at once. When its transfer starts, the block multiplies block size by block count and then by a fixed number of cycles per word to get a countdown. The surrounding system reduces the countdown with the number of cycles elapsed on each update. The channel completes when the countdown runs out. A transfer of size zero is reported as an error and starts no countdown. A plain write port updates the control bits, and the whole word is always readable.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the word reads 0, irq_o and size_err_o are 0 and no countdown runs, so update ticks alone produce no completion.
- R2: Word layout: bit 15 is force, bits 16+n are channel enables, bit 23 is master enable, bits 24+n are channel flags and bit 31 is the master flag. Bits 0 to 14 read 0. A completion on done_i[n] sets flag 24+n only when enable 16+n is 1. Otherwise the word is unchanged.
- R3: On every flag-setting event, bit 31 becomes force OR (master enable AND any flag). If that condition is false, bit 31 is cleared.
- R4: irq_o is high for exactly the one clock after a flag-setting event whose master condition holds, and it is low otherwise.
- R5: A start_i with size = blk_size_i * blk_cnt_i > 0 loads a countdown of size * 24 cycles. Each tick_i subtracts elapsed_i. The delayed channel (enable bit 22, flag bit 30) completes on the tick where elapsed_i >= the remaining count, and the countdown then goes idle.
- R6: A start_i with size 0 raises size_err_o for one clock and leaves the countdown as it was.
- R7: A start_i while a countdown runs reloads it with the new delay, and only one completion follows.
- R8: done_i bit 6, the delayed channel's bit, has no effect.
- R9: A write sets force, the enables and master enable from wr_data_i. A write clears each flag whose bit in wr_data_i is 1. Bit 31 ignores the written value and is recomputed as in R3. A write alone never pulses irq_o.
- R10: When a write and a completion fall in the same cycle, the write is applied first, and the completion is judged against the newly written enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control and status word |
| done_i | input | 7 | Per-channel completion strobes |
| start_i | input | 1 | Delayed-channel transfer start |
| blk_size_i | input | 8 | Delayed-channel block size |
| blk_cnt_i | input | 8 | Delayed-channel block count |
| tick_i | input | 1 | Countdown update strobe |
| elapsed_i | input | 8 | Cycles elapsed for this update |
| irq_o | output | 1 | One-clock interrupt request pulse |
| size_err_o | output | 1 | One-clock pulse on a zero-size start |

## Verification
The bench runs directed cases for each case that is easy to confuse with another: an enabled versus a disabled channel, the force bit versus the master enable, and a countdown that lands exactly on zero versus one that overshoots. A reload in the middle of a countdown must yield a single late completion rather than two. Random stretches mix writes, completions on all channels including the ignored bit, starts with small and zero sizes, and ticks of varied length. These show whether write-first ordering, write-one-to-clear and master recomputation keep agreeing with a cycle model over long event histories.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_CH    = 7;
  localparam int unsigned FORCE_BIT = 15;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned MEN_BIT   = 23;
  localparam int unsigned FLG_LSB   = 24;
  localparam int unsigned MST_BIT   = 31;
endpackage

// File: rtl/dma_irq_delay.sv
module dma_irq_delay #(
  parameter int unsigned SIZE_W     = 8,
  parameter int unsigned ELAPSED_W  = 8,
  parameter int unsigned DELAY_MULT = 24,
  localparam int unsigned CNT_W     = 2 * SIZE_W + $clog2(DELAY_MULT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [SIZE_W-1:0]    blk_size_i,
  input  logic [SIZE_W-1:0]    blk_cnt_i,
  input  logic                 tick_i,
  input  logic [ELAPSED_W-1:0] elapsed_i,
  output logic                 fire_o,
  output logic                 size_err_o
);
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                act_q, act_d;
  logic                err_d;
  logic [2*SIZE_W-1:0] size;
  logic [CNT_W-1:0]    elapsed_ext;

  assign size        = blk_size_i * blk_cnt_i;
  assign elapsed_ext = CNT_W'(elapsed_i);

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    err_d  = 1'b0;
    fire_o = 1'b0;
    if (start_i && size == '0) err_d = 1'b1;
    if (start_i && size != '0) begin
      // reload wins over a same-cycle tick
      cnt_d = CNT_W'(size) * CNT_W'(DELAY_MULT);
      act_d = 1'b1;
    end else if (tick_i && act_q) begin
      if (elapsed_ext >= cnt_q) begin
        fire_o = 1'b1;
        act_d  = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - elapsed_ext;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      act_q      <= 1'b0;
      size_err_o <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      act_q      <= act_d;
      size_err_o <= err_d;
    end
  end

  AST_ZERO_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && size == '0 && !act_q) |=> !act_q); // R6
  AST_FIRE_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (!act_q && cnt_q == '0)); // R5
endmodule

// File: rtl/dma_irq_reg.sv
module dma_irq_reg
  import dma_irq_pkg::*;
#(
  parameter int unsigned DLY_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              dly_done_i,
  output logic [REG_W-1:0]  ctl_o,
  output logic              irq_o
);
  logic              force_q, force_d;
  logic              men_q, men_d;
  logic              mst_q, mst_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [NUM_CH-1:0] flg_q, flg_d;
  logic [NUM_CH-1:0] evt, set;
  logic              cond, irq_d;

  always_comb begin
    force_d = force_q;
    men_d   = men_q;
    en_d    = en_q;
    flg_d   = flg_q;
    mst_d   = mst_q;
    // write is applied before same-cycle events
    if (wr_en_i) begin
      force_d = wr_data_i[FORCE_BIT];
      men_d   = wr_data_i[MEN_BIT];
      en_d    = wr_data_i[EN_LSB +: NUM_CH];
      flg_d   = flg_q & ~wr_data_i[FLG_LSB +: NUM_CH];
    end
    evt         = done_i;
    evt[DLY_CH] = dly_done_i;
    set         = evt & en_d;
    flg_d       = flg_d | set;
    cond        = force_d | (men_d & (|flg_d));
    if (wr_en_i || (|set)) mst_d = cond;
    irq_d = (|set) & cond;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= 1'b0;
      men_q   <= 1'b0;
      mst_q   <= 1'b0;
      en_q    <= '0;
      flg_q   <= '0;
      irq_o   <= 1'b0;
    end else begin
      force_q <= force_d;
      men_q   <= men_d;
      mst_q   <= mst_d;
      en_q    <= en_d;
      flg_q   <= flg_d;
      irq_o   <= irq_d;
    end
  end

  always_comb begin
    ctl_o                         = '0;
    ctl_o[FORCE_BIT]              = force_q;
    ctl_o[EN_LSB +: NUM_CH]       = en_q;
    ctl_o[MEN_BIT]                = men_q;
    ctl_o[FLG_LSB +: NUM_CH]      = flg_q;
    ctl_o[MST_BIT]                = mst_q;
  end

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flg_q & ~$past(flg_q) & ~en_q) == '0)); // R2
  AST_MASTER_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_q == (force_q | (men_q & (|flg_q)))); // R3
  AST_IRQ_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mst_q); // R4
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned DLY_CH     = 6,
  parameter int unsigned SIZE_W     = 8,
  parameter int unsigned ELAPSED_W  = 8,
  parameter int unsigned DELAY_MULT = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  output logic [REG_W-1:0]     rd_data_o,
  input  logic [NUM_CH-1:0]    done_i,
  input  logic                 start_i,
  input  logic [SIZE_W-1:0]    blk_size_i,
  input  logic [SIZE_W-1:0]    blk_cnt_i,
  input  logic                 tick_i,
  input  logic [ELAPSED_W-1:0] elapsed_i,
  output logic                 irq_o,
  output logic                 size_err_o
);
  logic dly_fire;

  dma_irq_delay #(
    .SIZE_W    (SIZE_W),
    .ELAPSED_W (ELAPSED_W),
    .DELAY_MULT(DELAY_MULT)
  ) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .blk_size_i(blk_size_i),
    .blk_cnt_i (blk_cnt_i),
    .tick_i    (tick_i),
    .elapsed_i (elapsed_i),
    .fire_o    (dly_fire),
    .size_err_o(size_err_o)
  );

  dma_irq_reg #(
    .DLY_CH(DLY_CH)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .done_i    (done_i),
    .dly_done_i(dly_fire),
    .ctl_o     (rd_data_o),
    .irq_o     (irq_o)
  );

  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[FORCE_BIT-1:0] == '0); // R2
endmodule

// File: tb/dma_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb_top;
  localparam int DLY = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [6:0]  done = '0;
  logic        start = 1'b0;
  logic [7:0]  bsz = '0, bcnt = '0;
  logic        tick = 1'b0;
  logic [7:0]  elapsed = '0;
  logic        irq, serr;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_ctl;
  int          m_cnt;
  bit          m_act;
  bit          e_irq, e_err;

  always #4 clk = ~clk;

  dma_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .done_i(done), .start_i(start), .blk_size_i(bsz),
    .blk_cnt_i(bcnt), .tick_i(tick), .elapsed_i(elapsed), .irq_o(irq),
    .size_err_o(serr)
  );

  function automatic bit master_cond(logic [31:0] c);
    return c[15] | (c[23] & (|c[30:24]));
  endfunction

  function automatic void model_step(bit w, logic [31:0] wd, logic [6:0] dn, bit st,
                                     int bs, int bc, bit tk, int el);
    logic [31:0] c = m_ctl;
    logic [6:0]  ev, st_v;
    bit fire = 0;
    e_irq = 0;
    e_err = 0;
    if (w) begin
      c[15]    = wd[15];
      c[23:16] = wd[23:16];
      c[30:24] = c[30:24] & ~wd[30:24];
      c[31]    = master_cond(c);
    end
    if (st && bs * bc == 0) e_err = 1;
    if (st && bs * bc != 0) begin
      m_cnt = bs * bc * 24;
      m_act = 1;
    end else if (tk && m_act) begin
      if (el >= m_cnt) begin
        fire = 1; m_act = 0; m_cnt = 0;
      end else m_cnt = m_cnt - el;
    end
    ev = dn;
    ev[DLY] = fire;
    st_v = ev & c[22:16];
    if (st_v != '0) begin
      c[30:24] = c[30:24] | st_v;
      c[31]    = master_cond(c);
      e_irq    = c[31];
    end
    m_ctl = c;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, logic [31:0] wd, logic [6:0] dn, bit st,
                      int bs, int bc, bit tk, int el);
    @(negedge clk);
    wr_en = w; wr_data = wd; done = dn; start = st;
    bsz = 8'(bs); bcnt = 8'(bc); tick = tk; elapsed = 8'(el);
    model_step(w, wd, dn, st, bs, bc, tk, el);
    @(posedge clk);
    #1;
    check(tag, "word", rd_data, m_ctl);
    check(tag, "irq", {31'b0, irq}, {31'b0, e_irq});
    check(tag, "size_err", {31'b0, serr}, {31'b0, e_err});
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, '0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic tck(string tag, int el);
    step(tag, 0, '0, '0, 0, 0, 0, 1, el);
  endtask

  task automatic wr(string tag, logic [31:0] d);
    step(tag, 1, d, '0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ctl = '0; m_cnt = 0; m_act = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset word", rd_data, 32'h0);
    check("R1", "reset irq", {31'b0, irq}, 32'h0);
    check("R1", "reset err", {31'b0, serr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: enable everything, ticks alone must not complete
    wr("R1", 32'h00FF_8000);
    wr("R1", 32'h00FF_0000);
    for (int i = 0; i < 5; i++) tck("R1", 200);
    // R2/R3/R4: enabled channel 2 completes with master enable
    step("R2", 0, '0, 7'b000_0100, 0, 0, 0, 0, 0);
    idle("R4", 1);
    // R9: clear flag 26 via write-one-to-clear, attempt to write bit 31
    wr("R9", 32'h8480_0000 | 32'h0000_0000);
    wr("R9", 32'h0480_0000);
    // R2: disabled channel has no effect
    wr("R2", 32'h0080_0001);
    step("R2", 0, '0, 7'b000_0010, 0, 0, 0, 0, 0);
    // R3: no master enable, no force -> bit 31 clears, no irq
    wr("R3", 32'h0002_0000);
    step("R3", 0, '0, 7'b000_0010, 0, 0, 0, 0, 0);
    // R3: force bit alone
    wr("R3", 32'h0002_8000 | 32'h0200_0000);
    step("R3", 0, '0, 7'b000_0010, 0, 0, 0, 0, 0);
    // R10: write enabling channel 0 in same cycle as its completion
    wr("R10", 32'h7F00_0000);
    step("R10", 1, 32'h0081_0000, 7'b000_0001, 0, 0, 0, 0, 0);
    // R5: exact landing on zero, 1*1*24
    wr("R5", 32'h7FC0_0000);
    step("R5", 0, '0, '0, 1, 1, 1, 0, 0);
    tck("R5", 10); tck("R5", 10); tck("R5", 4); idle("R5", 1);
    // R5: overshoot, 2*3*24 = 144
    wr("R5", 32'h7FC0_0000);
    step("R5", 0, '0, '0, 1, 2, 3, 0, 0);
    tck("R5", 100); tck("R5", 43); tck("R5", 50); tck("R5", 50);
    // R6: zero size reports error, no countdown
    wr("R6", 32'h7FC0_0000);
    step("R6", 0, '0, '0, 1, 0, 5, 0, 0);
    tck("R6", 255); tck("R6", 255);
    // R7: reload mid-countdown, single completion
    step("R7", 0, '0, '0, 1, 1, 1, 0, 0);
    tck("R7", 20);
    step("R7", 0, '0, '0, 1, 1, 1, 0, 0);
    tck("R7", 20); tck("R7", 4);
    wr("R7", 32'h7FC0_0000);
    tck("R7", 200); tck("R7", 200);
    // R8: done bit of delayed channel ignored
    step("R8", 0, '0, 7'b100_0000, 0, 0, 0, 0, 0);
    step("R8", 0, '0, 7'b100_0000, 0, 0, 0, 0, 0);
    // random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      bit          w  = ($urandom % 8) == 0;
      logic [31:0] wd = $urandom;
      logic [6:0]  dn = (($urandom % 4) == 0) ? 7'($urandom) : 7'b0;
      bit          st = ($urandom % 20) == 0;
      int          bs = $urandom % 4;
      int          bc = $urandom % 3;
      bit          tk = ($urandom % 2) == 0;
      int          el = $urandom % 48;
      step("RND", w, wd, dn, st, bs, bc, tk, el);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule